// File: doc/BRIEF.md
# Ones-Run Count and Replay Unit

The unit watches a one-bit serial input and measures the length of each unbroken run of 1s with a small saturating counter. When the run ends, it plays the measured length back on its output as a train of single-clock high pulses. The train starts in the very clock in which the input first reads 0, because the output is formed combinationally from the input and the stored state.

Once a train has started, a replay flag locks out the input. The input is not looked at again until the last pulse has been sent, so 1s that arrive during playback are neither counted nor allowed to cut the train short. The counter is four bits wide. A run longer than fifteen clocks is clipped to fifteen. The counter also sets the direction: it counts up while a run is being measured and counts down while pulses are being sent.

Top module: `ones_replay_unit`

## Requirements
- R1: A synchronous active-high reset clears the counter and the replay flag. While reset is held and after it is released, z stays 0 until a run of 1s has been measured.
- R2: While no replay is in progress and x is 1, z is 0 and each such clock adds one to the stored count.
- R3: After a run of N 1s (1 ≤ N ≤ 15), z is 1 in the first clock where x is 0 and in the N−1 clocks that follow. That is exactly N consecutive high clocks, and z is 0 after them.
- R4: A run longer than 15 clocks stores the count 15 and holds it there. Its replay is exactly 15 high clocks.
- R5: Once a replay has started, the value of x has no effect until the last pulse. 1s driven during the replay neither lengthen nor shorten the train.
- R6: When x is 0 and the stored count is zero, z is 0 and the count does not change. A run of length 0 produces no pulse.
- R7: 1s received during a replay are not counted. A run that starts in the clock after the last pulse is measured from zero.
- R8: A reset applied in the middle of a replay ends it. z is 0 from the clock after the reset edge, and no leftover pulses follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| x | input | 1 | Serial input whose runs of 1s are measured |
| z | output | 1 | Replay pulse output, one high clock per counted 1 |

## Verification
The assertions assume that x is a clean value that is stable around each rising edge, and that reset is held high from time zero for at least one edge. They make no assumption about when x changes relative to a replay, so the lockout is checked under any input pattern. The bench changes x only on falling edges and samples z just after, before the next rising edge. After each measured run it drives at least sixteen 0s, so every replay ends before the next run begins, except in the directed lockout and back-to-back cases, which break that spacing on purpose.

// File: rtl/orc_pkg.sv
package orc_pkg;
  parameter int CNT_W = 4;
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  typedef logic [CNT_W-1:0] cnt_t;

  function automatic cnt_t cnt_up(input cnt_t c);
    return (c == cnt_t'(CNT_MAX)) ? c : c + cnt_t'(1);
  endfunction

  function automatic cnt_t cnt_down(input cnt_t c);
    return (c == '0) ? c : c - cnt_t'(1);
  endfunction

  function automatic logic cnt_last(input cnt_t c);
    return c == cnt_t'(1);
  endfunction

  function automatic logic cnt_full(input cnt_t c);
    return c == cnt_t'(CNT_MAX);
  endfunction
endpackage

// File: rtl/orc_counter.sv
module orc_counter
  import orc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic down,
  output cnt_t cnt
);
  always_ff @(posedge clk) begin
    if (rst)     cnt <= '0;
    else if (en) cnt <= down ? cnt_down(cnt) : cnt_up(cnt);
  end

  p_reset_r1: assert property (@(posedge clk) rst |=> (cnt == '0));
  p_down_step_r3: assert property (@(posedge clk) disable iff (rst)
    (en && down) |=> (cnt == $past(cnt) - cnt_t'(1)));
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(cnt));
endmodule

// File: rtl/orc_ctrl.sv
module orc_ctrl
  import orc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic x,
  input  cnt_t cnt,
  output logic replay_q,
  output logic z,
  output logic cnt_en,
  output logic cnt_down_sel
);
  logic nonzero;
  logic full;
  logic start_evt;
  logic end_evt;
  logic measure_evt;

  assign nonzero      = (cnt != '0);
  assign full         = cnt_full(cnt);
  assign z            = replay_q | (!x & nonzero);
  assign start_evt    = !replay_q & !x & nonzero;
  assign end_evt      = z & cnt_last(cnt);
  assign measure_evt  = !replay_q & x & !full;
  assign cnt_en       = z | measure_evt;
  assign cnt_down_sel = z;

  always_ff @(posedge clk) begin
    if (rst) replay_q <= 1'b0;
    else     replay_q <= z & !end_evt;
  end

  p_reset_r1: assert property (@(posedge clk) rst |=> !replay_q);
  p_quiet_while_counting_r2: assert property (@(posedge clk) disable iff (rst)
    (!replay_q && x) |-> !z);
  p_count_up_r2: assert property (@(posedge clk) disable iff (rst)
    (!replay_q && x && !full) |=> (cnt == $past(cnt) + cnt_t'(1)));
  p_saturate_r4: assert property (@(posedge clk) disable iff (rst)
    (!replay_q && x && full) |=> full);
  p_lockout_r5: assert property (@(posedge clk) disable iff (rst)
    replay_q |-> (z && nonzero));
  p_flag_clear_r3: assert property (@(posedge clk) disable iff (rst)
    end_evt |=> (!replay_q && !nonzero));
  p_flag_set_r3: assert property (@(posedge clk) disable iff (rst)
    (start_evt && !cnt_last(cnt)) |=> replay_q);
  p_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (!x && !nonzero && !replay_q) |-> !z);
endmodule

// File: rtl/ones_replay_unit.sv
module ones_replay_unit
  import orc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic x,
  output logic z
);
  cnt_t cnt;
  logic replay_q;
  logic cnt_en;
  logic cnt_down_sel;

  orc_counter u_counter (
    .clk  (clk),
    .rst  (rst),
    .en   (cnt_en),
    .down (cnt_down_sel),
    .cnt  (cnt)
  );

  orc_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .x            (x),
    .cnt          (cnt),
    .replay_q     (replay_q),
    .z            (z),
    .cnt_en       (cnt_en),
    .cnt_down_sel (cnt_down_sel)
  );

  p_reset_out_r8: assert property (@(posedge clk) rst |=> !z || (!x && cnt != '0));
endmodule

// File: tb/ones_replay_unit_tb_top.sv
`timescale 1ns/1ps
module ones_replay_unit_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic x   = 1'b0;
  logic z;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  localparam int NRUNS = 12;
  localparam int RUNS [NRUNS] = '{0, 1, 2, 3, 7, 14, 15, 16, 20, 1, 15, 0};
  localparam int GAP = 17;

  always #2 clk = ~clk;

  ones_replay_unit dut_i (.clk(clk), .rst(rst), .x(x), .z(z));

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int expect_len(input int run);
    return (run > 15) ? 15 : run;
  endfunction

  task automatic drive(input logic v);
    @(negedge clk);
    x = v;
    #0.5;
  endtask

  task automatic play(input int run, input int gap);
    int n;
    n = expect_len(run);
    for (int i = 0; i < run; i++) begin
      drive(1'b1);
      chk(z, 1'b0, "R2");
    end
    for (int i = 0; i < gap; i++) begin
      drive(1'b0);
      if (run == 0) chk(z, 1'b0, "R6");
      else if (run > 15) chk(z, logic'(i < n), "R4");
      else chk(z, logic'(i < n), "R3");
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset held with x high keeps z low
    for (int i = 0; i < 4; i++) begin
      drive(1'b1);
      chk(z, 1'b0, "R1");
    end
    @(negedge clk);
    rst = 1'b0;
    x = 1'b0;
    for (int i = 0; i < 3; i++) begin
      drive(1'b0);
      chk(z, 1'b0, "R1");
    end

    for (int k = 0; k < NRUNS; k++) play(RUNS[k], GAP);

    for (int k = 0; k < 30; k++) play(int'($urandom_range(20, 0)), GAP);

    // R5 and R7: 1s during the replay are ignored and not counted
    for (int i = 0; i < 5; i++) drive(1'b1);
    drive(1'b0);
    chk(z, 1'b1, "R5");
    for (int i = 0; i < 4; i++) begin
      drive(1'b1);
      chk(z, 1'b1, "R5");
    end
    for (int i = 0; i < 8; i++) begin
      drive(1'b0);
      chk(z, 1'b0, "R7");
    end

    // R7: a run right after the last pulse is counted from zero
    for (int i = 0; i < 3; i++) drive(1'b1);
    drive(1'b0);
    chk(z, 1'b1, "R7");
    drive(1'b0);
    chk(z, 1'b1, "R7");
    drive(1'b1);
    chk(z, 1'b1, "R5");
    drive(1'b1);
    chk(z, 1'b0, "R7");
    drive(1'b1);
    chk(z, 1'b0, "R7");
    drive(1'b0);
    chk(z, 1'b1, "R7");
    drive(1'b0);
    chk(z, 1'b1, "R7");
    drive(1'b0);
    chk(z, 1'b0, "R7");

    // R8: reset in the middle of a replay
    for (int i = 0; i < 9; i++) drive(1'b1);
    drive(1'b0);
    chk(z, 1'b1, "R3");
    @(negedge clk);
    rst = 1'b1;
    drive(1'b0);
    chk(z, 1'b0, "R8");
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 10; i++) begin
      drive(1'b0);
      chk(z, 1'b0, "R8");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule